// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block is the command side of a per-processor interrupt controller. Software writes the target identifier into a high command word. It then writes a low command word that holds the vector, the delivery mode, the trigger and level bits and a destination shorthand. The write to the low word launches one interrupt message on a valid/ready message port. The message is held on the port until the fabric takes it. While it waits, a delivery-status bit in the low word reads as 1. Software polls that bit before it issues the next command.

The unit also has a read-only identifier register, from which software learns which processor it runs on. Register writes are always full 32-bit words. Reads are combinational on the address, and bits with no defined meaning read as zero. Message arbitration and the behaviour of the receiving processors lie outside this block.

Top module: `ipi_command_unit`

## Requirements
- R1: After reset the low word, the high word and msgValid are all zero.
- R2: Offset 0x020 reads the parameter UNIT_ID in bits 31:24 and zero in every other bit. Writes to this offset change nothing.
- R3: Offset 0x310 stores the destination in bits 31:24. A read returns that field, with all other bits zero.
- R4: A write to offset 0x300 while no message is pending raises msgValid on the next cycle. The message carries these fields of the written word: vector from bits 7:0, mode from bits 10:8 (000 fixed, 101 INIT/reset, 110 startup, where the vector holds the entry page number), assert from bit 14 and level trigger from bit 15.
- R5: Reading offset 0x300 returns the stored bits 19:18, 15:14 and 10:0. Bit 12 reads 1 while a message is pending, and all other bits read 0.
- R6: msgValid and every message field stay constant until msgReady is seen high with msgValid. On the cycle after that handshake, msgValid is 0 and bit 12 of the low word reads 0.
- R7: A write to offset 0x300 while a message is pending is ignored. The pending message and the stored low word are unchanged, and no second message follows.
- R8: The shorthand in bits 19:18 sets msgDest. With 00, msgDest is the high-word destination. With 01, it is UNIT_ID. With 10 (all including self) or 11 (all except self), it is 8'hFF and the high word is ignored.
- R9: A write to the high word while a message is pending does not change the in-flight msgDest. The next message uses the new value.
- R10: Offsets other than 0x020, 0x300 and 0x310 read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | 32-bit register write strobe |
| regAddr | input | 12 | Byte offset for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational on regAddr |
| msgValid | output | 1 | Message present on the port |
| msgReady | input | 1 | Fabric accepts the message |
| msgDest | output | 8 | Resolved destination identifier |
| msgMode | output | 3 | Delivery mode |
| msgVector | output | 8 | Vector or startup page number |
| msgAssert | output | 1 | 1 = assert, 0 = deassert |
| msgLevelTrig | output | 1 | 1 = level, 0 = edge trigger |
| msgShorthand | output | 2 | Destination shorthand |

## Verification
The bench goes after a command written while one is still pending. A design that let that write through would corrupt the vector on a live port or send a second message. It also rewrites the high word during a pending send; a design that resolved the destination late would retarget the in-flight message. Each shorthand value is tried against a non-zero high word, so a broadcast that leaked the high-word destination is caught. The ready delay is varied from zero to several cycles, which exposes a status bit that clears too early or too late and fields that drift while the port waits. Reserved bits are written as ones to catch storage that reads them back.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 8;
  localparam int ID_LSB = DATA_W - ID_W;

  localparam logic [ADDR_W-1:0] OFF_ID   = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_LOW  = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_HIGH = 12'h310;

  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 3;
  localparam int BUSY_BIT  = 12;
  localparam int ASSERT_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SHORT_LSB = 18;
  localparam int SHORT_W   = 2;

  localparam logic [DATA_W-1:0] LOW_WR_MASK = 32'h000C_C7FF;

  typedef enum logic [1:0] {
    SH_NONE    = 2'b00,
    SH_SELF    = 2'b01,
    SH_ALL     = 2'b10,
    SH_OTHERS  = 2'b11
  } shorthand_t;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_SEND = 1'b1
  } ctrlState_t;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic launch;
  } ipiStrobes_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              msgReady,
  output ipiStrobes_t       strobes,
  output logic              sendBusy
);
  ctrlState_t state, stateNext;
  logic wrLow, wrHigh;

  always_comb begin
    wrLow  = regWrEn && (regAddr == OFF_LOW);
    wrHigh = regWrEn && (regAddr == OFF_HIGH);
    strobes.loadHigh = wrHigh;
    strobes.loadLow  = wrLow && (state == CTRL_IDLE);
    strobes.launch   = wrLow && (state == CTRL_IDLE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      CTRL_IDLE: if (strobes.launch) stateNext = CTRL_SEND;
      CTRL_SEND: if (msgReady)       stateNext = CTRL_IDLE;
      default:                       stateNext = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CTRL_IDLE;
    else       state <= stateNext;
  end

  assign sendBusy = (state == CTRL_SEND);

  assert_launch_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |=> sendBusy);
  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sendBusy && !msgReady) |=> sendBusy);
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sendBusy && msgReady) |=> !sendBusy);
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_cmd_pkg::*;
#(
  parameter logic [ID_W-1:0] UNIT_ID = 8'h05
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  ipiStrobes_t       strobes,
  input  logic              sendBusy,
  output logic [DATA_W-1:0] regRdData,
  output logic [ID_W-1:0]   msgDest,
  output logic [MODE_W-1:0] msgMode,
  output logic [VEC_W-1:0]  msgVector,
  output logic              msgAssert,
  output logic              msgLevelTrig,
  output logic [SHORT_W-1:0] msgShorthand
);
  logic [DATA_W-1:0] lowReg;
  logic [ID_W-1:0]   destHigh;
  logic [ID_W-1:0]   destLatched;
  logic [ID_W-1:0]   destResolved;
  shorthand_t        wrShort;

  always_comb begin
    wrShort = shorthand_t'(regWrData[SHORT_LSB +: SHORT_W]);
    unique case (wrShort)
      SH_NONE:   destResolved = destHigh;
      SH_SELF:   destResolved = UNIT_ID;
      default:   destResolved = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg      <= '0;
      destHigh    <= '0;
      destLatched <= '0;
    end else begin
      if (strobes.loadLow)  lowReg   <= regWrData & LOW_WR_MASK;
      if (strobes.loadHigh) destHigh <= regWrData[ID_LSB +: ID_W];
      if (strobes.launch)   destLatched <= destResolved;
    end
  end

  assign msgDest      = destLatched;
  assign msgMode      = lowReg[MODE_LSB +: MODE_W];
  assign msgVector    = lowReg[VEC_LSB +: VEC_W];
  assign msgAssert    = lowReg[ASSERT_BIT];
  assign msgLevelTrig = lowReg[TRIG_BIT];
  assign msgShorthand = lowReg[SHORT_LSB +: SHORT_W];

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      OFF_ID:   regRdData[ID_LSB +: ID_W] = UNIT_ID;
      OFF_HIGH: regRdData[ID_LSB +: ID_W] = destHigh;
      OFF_LOW: begin
        regRdData = lowReg;
        regRdData[BUSY_BIT] = sendBusy;
      end
      default:  regRdData = '0;
    endcase
  end

  assert_low_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sendBusy && regWrEn && regAddr == OFF_LOW) |=> $stable(lowReg));
  assert_fields_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sendBusy && !strobes.launch) |=> ($stable(lowReg) && $stable(destLatched)));
  assert_bcast_dest_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.launch && regWrData[SHORT_LSB+1]) |=> (destLatched == '1));
endmodule

// File: rtl/ipi_command_unit.sv
module ipi_command_unit
  import ipi_cmd_pkg::*;
#(
  parameter logic [7:0] UNIT_ID = 8'h05
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        msgValid,
  input  logic        msgReady,
  output logic [7:0]  msgDest,
  output logic [2:0]  msgMode,
  output logic [7:0]  msgVector,
  output logic        msgAssert,
  output logic        msgLevelTrig,
  output logic [1:0]  msgShorthand
);
  ipiStrobes_t strobes;
  logic        sendBusy;

  ipi_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .msgReady (msgReady),
    .strobes  (strobes),
    .sendBusy (sendBusy)
  );

  ipi_datapath #(.UNIT_ID(UNIT_ID)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .strobes      (strobes),
    .sendBusy     (sendBusy),
    .regRdData    (regRdData),
    .msgDest      (msgDest),
    .msgMode      (msgMode),
    .msgVector    (msgVector),
    .msgAssert    (msgAssert),
    .msgLevelTrig (msgLevelTrig),
    .msgShorthand (msgShorthand)
  );

  assign msgValid = sendBusy;
endmodule

// File: tb/ipi_command_unit_test.sv
`timescale 1ns/1ps
module ipi_command_unit_test;
  localparam logic [7:0]  MY_ID = 8'h05;
  localparam logic [11:0] A_ID = 12'h020, A_LOW = 12'h300, A_HIGH = 12'h310;
  localparam logic [31:0] RES_MASK = 32'h000C_C7FF;
  localparam int NV = 6;
  // {high word, low word, ready delay}
  localparam logic [95:0] VEC [NV] = '{
    {32'h0300_0000, 32'h0000_C500, 32'd0},
    {32'h0300_0000, 32'h0000_8500, 32'd2},
    {32'h0A00_0000, 32'h0000_0698, 32'd3},
    {32'h1100_0000, 32'hFFF7_3F41, 32'd1},
    {32'h2200_0000, 32'h0008_4031, 32'd1},
    {32'h7700_0000, 32'h000C_0010, 32'd0}
  };

  logic clk = 0, rstN = 0, regWrEn = 0, msgReady = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic msgValid, msgAssert, msgLevelTrig;
  logic [7:0] msgDest, msgVector;
  logic [2:0] msgMode;
  logic [1:0] msgShorthand;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipi_command_unit #(.UNIT_ID(MY_ID)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  function automatic logic [7:0] expDest(input logic [31:0] hi, input logic [31:0] lo);
    case (lo[19:18])
      2'b00: return hi[31:24];
      2'b01: return MY_ID;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chkMsg(input string tag, input logic [31:0] lo, input logic [7:0] dst);
    chk({tag, " valid"}, {31'd0, msgValid}, 32'd1);
    chk({tag, " fields"},
        {11'd0, msgShorthand, msgLevelTrig, msgAssert, msgMode, msgVector, msgDest},
        {11'd0, lo[19:18], lo[15], lo[14], lo[10:8], lo[7:0], dst});
  endtask

  task automatic accept();
    @(negedge clk); msgReady = 1;
    @(negedge clk); msgReady = 0;
  endtask

  initial begin
    logic [31:0] r, hi, lo, dl;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    rd(A_LOW, r);  chk("R1 low reset", r, 32'h0);
    rd(A_HIGH, r); chk("R1 high reset", r, 32'h0);
    chk("R1 valid reset", {31'd0, msgValid}, 32'd0);
    // R2: identifier register, read-only
    rd(A_ID, r); chk("R2 id read", r, {MY_ID, 24'h0});
    wr(A_ID, 32'hFFFF_FFFF);
    rd(A_ID, r); chk("R2 id write ignored", r, {MY_ID, 24'h0});
    // R10: unmapped offsets
    wr(12'h100, 32'hDEAD_BEEF);
    rd(12'h100, r); chk("R10 unmapped read", r, 32'h0);
    chk("R10 unmapped no send", {31'd0, msgValid}, 32'd0);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      {hi, lo, dl} = VEC[i];
      wr(A_HIGH, hi);
      rd(A_HIGH, r); chk("R3 high readback", r, {hi[31:24], 24'h0});
      wr(A_LOW, lo);
      chkMsg("R4 R8 launch", lo, expDest(hi, lo));
      rd(A_LOW, r); chk("R5 pending readback", r, (lo & RES_MASK) | 32'h1000);
      for (int k = 0; k < int'(dl); k++) begin
        @(negedge clk);
        chkMsg("R6 hold", lo, expDest(hi, lo));
      end
      accept();
      chk("R6 valid drop", {31'd0, msgValid}, 32'd0);
      rd(A_LOW, r); chk("R6 R5 status clear", r, lo & RES_MASK);
    end

    // R7: write to low while pending
    wr(A_HIGH, 32'h3300_0000);
    wr(A_LOW, 32'h0000_0021);
    wr(A_LOW, 32'h0008_C5EE);
    chkMsg("R7 pending kept", 32'h0000_0021, 8'h33);
    rd(A_LOW, r); chk("R7 low unchanged", r, 32'h0000_1021);
    accept();
    @(negedge clk);
    chk("R7 no second send", {31'd0, msgValid}, 32'd0);

    // R9: high write during pending
    wr(A_LOW, 32'h0000_0042);
    wr(A_HIGH, 32'h4400_0000);
    chk("R9 dest in flight", {24'd0, msgDest}, 32'h33);
    accept();
    wr(A_LOW, 32'h0000_0043);
    chk("R9 next dest", {24'd0, msgDest}, 32'h44);
    accept();
    // R8: broadcast ignores high word
    wr(A_LOW, 32'h0008_0050);
    chk("R8 bcast dest", {24'd0, msgDest}, 32'hFF);
    accept();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule